// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator Synthesiser

This block is a phase-accumulator frequency synthesiser built for clock rates where one wide adder cannot settle in a single cycle. The accumulator is divided into segments. Each segment is a short adder with its own state register, and a flip-flop sits on the carry path between neighbouring segments. The longest combinational carry path is therefore one segment wide and does not grow with the full accumulator width. Segment k runs exactly k cycles behind segment 0.

The main output is the registered carry out of the most significant segment. It is used as a square-wave or pulse-rate clock enable whose average rate is `ftw / 2^ACC_W` of the clock. This bit stream is the same as the carry stream of a plain single-adder accumulator, only shifted later in time by the number of carry flip-flops. The tuning word is captured on a load strobe. Each upper segment receives the captured word after the same skew as its carry, so word changes stay consistent.

A second output shows the full phase word. It is realigned by delaying the lower segments, so it lags the phase of a plain accumulator by the same amount. Widths of about 30 bits, which give part-per-billion resolution, are supported through parameters.

Top module: `carry_pipe_dds`

## Requirements
- R1: While `rst_n` is low at a rising edge, every segment, carry flip-flop and word register is cleared, so from the next cycle `carry_o` is 0 and `phase_o` is 0.
- R2: `ftw_i` is captured into the active word only at a rising edge with `load_i` high. While `load_i` is low, `ftw_i` has no effect, so after settling `phase_o` advances by exactly the captured word every cycle.
- R3: `carry_o` equals the registered carry out of an unpipelined `ACC_W`-bit accumulator (`acc <= acc + word`) delayed by `NSEG-1` extra cycles. With the default 16 bits and 2 segments (split between bit 7 and bit 8) the extra delay is one cycle.
- R4: `phase_o` equals the state of that unpipelined accumulator delayed by `NSEG-1` cycles.
- R5: Back-to-back and mid-run word loads keep R3 exact, because each upper segment applies a new word after its own skew.
- R6: With an active word of 0, once the pipeline has drained `carry_o` stays 0 and `phase_o` holds still.
- R7: With the default 16-bit width and word 0x1000, `carry_o` is high in exactly 16 of any 256 consecutive cycles.
- R8: A 30-bit, 3-segment configuration (10-bit segments) meets R3 and R4 with a lag of two extra cycles.
- R9: When `ACC_W` does not divide evenly by `NSEG`, the top segment takes the remainder bits (for example 13 bits over 3 segments gives 4, 4 and 5 bits) and R3 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ftw_i | input | ACC_W | Frequency tuning word |
| load_i | input | 1 | Capture strobe for `ftw_i` |
| carry_o | output | 1 | Delayed top carry out (synthesiser output) |
| phase_o | output | ACC_W | Phase word, lagging by NSEG-1 cycles |

## Verification
A wrong carry flip-flop or a wrong word skew inside the pipeline appears at `carry_o` as a pulse that is missing, extra or shifted. It appears within the first wrap of the lower segment after the fault, which is a few cycles for large words, and `phase_o` shows the corrupt upper bits in the same cycle. The checks compare each configuration cycle by cycle against a plain accumulator delayed by its lag, under table-driven and random word changes. They also check the word-hold, idle-word and pulse-rate properties directly at the ports.

// File: rtl/dds_pkg.sv
// Package: segment geometry helpers for the carry-pipelined accumulator.
// Assumes segment k starts at bit k*seg_w; the top segment takes any remainder.
package dds_pkg;

    // Lowest accumulator bit held by segment k.
    function automatic int seg_lsb(input int k, input int seg_w);
        return k * seg_w;
    endfunction

    // Width of segment k; the top segment absorbs leftover bits.
    function automatic int seg_width(input int k, input int nseg,
                                     input int acc_w, input int seg_w);
        return (k == nseg - 1) ? (acc_w - k * seg_w) : seg_w;
    endfunction

endpackage

// File: rtl/dds_delay_line.sv
// Module: dds_delay_line
// Fixed-depth register delay for a W-bit word, cleared by synchronous reset.
// Assumes DEPTH >= 1; callers bypass it when no delay is needed.
module dds_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [DEPTH];

    // Shift the word one stage per clock; reset empties every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/dds_seg_acc.sv
// Module: dds_seg_acc
// One accumulator segment: adds its slice of the word and a registered carry-in,
// and registers both the new state and the carry out, so the next segment sees it a cycle later.
// Assumes add_i and cin_i are already skewed to this segment's lag.
module dds_seg_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] add_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W-1:0] acc_q;
    logic         cy_q;
    logic [W:0]   nxt;

    // Segment adder: one W-bit carry chain only.
    always_comb nxt = {1'b0, acc_q} + {1'b0, add_i} + {{W{1'b0}}, cin_i};

    // Register segment state and its carry out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            acc_q <= nxt[W-1:0];
            cy_q  <= nxt[W];
        end
    end

    assign sum_o  = acc_q;
    assign cout_o = cy_q;

    // A registered carry means the segment wrapped, so its state cannot have grown.
    assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cy_q) |-> (acc_q <= $past(acc_q)));

    // No carry means no wrap, so the state cannot have shrunk.
    assert_nowrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cy_q && $past(rst_n)) |-> (acc_q >= $past(acc_q)));

    // Nothing to add means the state holds.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i == '0 && !cin_i) |=> $stable(acc_q));
endmodule

// File: rtl/carry_pipe_dds.sv
// Module: carry_pipe_dds (top)
// Phase accumulator split into NSEG segments with a carry flip-flop between each pair.
// Segment k lags segment 0 by k cycles; its word slice is delayed by k to match.
// carry_o is the top segment's registered carry, i.e. a plain accumulator's carry delayed NSEG-1.
// phase_o realigns the segments by delaying the lower ones, lagging by NSEG-1 cycles.
// Assumes NSEG >= 1 and ACC_W >= NSEG.
module carry_pipe_dds
    import dds_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int NSEG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic             load_i,
    output logic             carry_o,
    output logic [ACC_W-1:0] phase_o
);
    localparam int SEG_W = ACC_W / NSEG;
    localparam int LAG   = NSEG - 1;

    logic [ACC_W-1:0] word_q;
    logic [NSEG:0]    cy;

    // Capture the tuning word on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= ftw_i;
    end

    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = seg_lsb(k, SEG_W);
        localparam int SW = seg_width(k, NSEG, ACC_W, SEG_W);
        localparam int AL = LAG - k;

        logic [SW-1:0] add_w;
        logic [SW-1:0] sum_w;

        if (k == 0) begin : g_word_now
            assign add_w = word_q[LO +: SW];
        end else begin : g_word_skew
            dds_delay_line #(.W(SW), .DEPTH(k)) u_wskew (
                .clk(clk), .rst_n(rst_n), .d_i(word_q[LO +: SW]), .q_o(add_w));
        end

        dds_seg_acc #(.W(SW)) u_seg (
            .clk(clk), .rst_n(rst_n), .add_i(add_w), .cin_i(cy[k]),
            .sum_o(sum_w), .cout_o(cy[k+1]));

        if (AL == 0) begin : g_ph_now
            assign phase_o[LO +: SW] = sum_w;
        end else begin : g_ph_align
            dds_delay_line #(.W(SW), .DEPTH(AL)) u_palign (
                .clk(clk), .rst_n(rst_n), .d_i(sum_w), .q_o(phase_o[LO +: SW]));
        end
    end

    assign carry_o = cy[NSEG];

    // Reset leaves both outputs at zero on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!carry_o && phase_o == '0));

    // The active word changes only under the load strobe.
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_q));
endmodule

// File: tb/carry_pipe_dds_tb.sv
// Reference: plain single-adder accumulator whose carry and phase are delayed by LAG cycles.
module dds_ref_model #(
    parameter int W   = 16,
    parameter int LAG = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ftw,
    input  logic         load,
    output logic         carry_d,
    output logic [W-1:0] phase_d
);
    logic [W-1:0] acc, word;
    logic [W:0]   s;
    logic         ch [0:LAG];
    logic [W-1:0] ph [0:LAG];

    always_comb s = {1'b0, acc} + {1'b0, word};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            word <= '0;
            for (int i = 0; i <= LAG; i++) begin ch[i] <= 1'b0; ph[i] <= '0; end
        end else begin
            acc   <= s[W-1:0];
            if (load) word <= ftw;
            ch[0] <= s[W];
            ph[0] <= s[W-1:0];
            for (int i = 1; i <= LAG; i++) begin ch[i] <= ch[i-1]; ph[i] <= ph[i-1]; end
        end
    end

    assign carry_d = ch[LAG];
    assign phase_d = ph[LAG];
endmodule

module carry_pipe_dds_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 8;
    localparam logic [31:0] FTW_TAB [NTAB] = '{
        32'h0000_0080, 32'h0000_4001, 32'h2AAA_5555, 32'h3FFF_FFFF,
        32'h0000_00FF, 32'h1234_8000, 32'h0000_0100, 32'h0155_AA7F };
    localparam int LEN_TAB [NTAB] = '{ 40, 0, 1, 30, 0, 25, 3, 60 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] ftw = '0;
    int          checks = 0;
    int          failures = 0;
    string       cur_tag = "R3";

    logic        c16, r16c, c30, r30c, c13, r13c;
    logic [15:0] p16, r16p;
    logic [29:0] p30, r30p;
    logic [12:0] p13, r13p;

    always #(CLK_PERIOD/2) clk = ~clk;

    carry_pipe_dds #(.ACC_W(16), .NSEG(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ftw_i(ftw[15:0]), .load_i(load),
        .carry_o(c16), .phase_o(p16));
    carry_pipe_dds #(.ACC_W(30), .NSEG(3)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .ftw_i(ftw[29:0]), .load_i(load),
        .carry_o(c30), .phase_o(p30));
    carry_pipe_dds #(.ACC_W(13), .NSEG(3)) u_dut_odd (
        .clk(clk), .rst_n(rst_n), .ftw_i(ftw[12:0]), .load_i(load),
        .carry_o(c13), .phase_o(p13));

    dds_ref_model #(.W(16), .LAG(1)) u_ref16 (
        .clk(clk), .rst_n(rst_n), .ftw(ftw[15:0]), .load(load), .carry_d(r16c), .phase_d(r16p));
    dds_ref_model #(.W(30), .LAG(2)) u_ref30 (
        .clk(clk), .rst_n(rst_n), .ftw(ftw[29:0]), .load(load), .carry_d(r30c), .phase_d(r30p));
    dds_ref_model #(.W(13), .LAG(2)) u_ref13 (
        .clk(clk), .rst_n(rst_n), .ftw(ftw[12:0]), .load(load), .carry_d(r13c), .phase_d(r13p));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Advance to the next falling edge and compare every configuration with its model.
    task automatic tick();
        @(negedge clk);
        chk(cur_tag, {31'b0, c16}, {31'b0, r16c});
        chk("R4", {16'b0, p16}, {16'b0, r16p});
        chk("R8", {31'b0, c30}, {31'b0, r30c});
        chk("R8", {2'b0, p30}, {2'b0, r30p});
        chk("R9", {31'b0, c13}, {31'b0, r13c});
        chk("R9", {19'b0, p13}, {19'b0, r13p});
    endtask

    task automatic load_word(input logic [31:0] w);
        ftw = w; load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    initial begin
        logic [15:0] prev;
        int pulses;
        // R1: reset with a load pending
        tick();
        ftw = 32'h1234_5678; load = 1'b1;
        tick();
        chk("R1", {31'b0, c16}, 32'd0);
        chk("R1", {16'b0, p16}, 32'd0);
        chk("R1", {2'b0, p30}, 32'd0);
        load = 1'b0;
        rst_n = 1'b1;
        tick();

        // R5: table of words and run lengths, including back-to-back loads
        cur_tag = "R5";
        for (int i = 0; i < NTAB; i++) begin
            load_word(FTW_TAB[i]);
            for (int j = 0; j < LEN_TAB[i]; j++) tick();
        end
        // R3: random words and dwell times
        cur_tag = "R3";
        for (int i = 0; i < 30; i++) begin
            load_word($urandom());
            for (int j = 0; j < int'($urandom_range(0, 40)); j++) tick();
        end

        // R2: input ignored without the strobe; phase steps by the captured word
        load_word(32'h0000_0100);
        ftw = 32'hFFFF_FFFF;
        repeat (4) tick();
        for (int i = 0; i < 10; i++) begin
            prev = p16;
            tick();
            chk("R2", {16'b0, p16 - prev}, 32'h0000_0100);
        end

        // R6: zero word drains to a silent, still output
        load_word(32'h0);
        repeat (4) tick();
        prev = p16;
        for (int i = 0; i < 40; i++) begin
            tick();
            chk("R6", {31'b0, c16}, 32'd0);
            chk("R6", {16'b0, p16}, {16'b0, prev});
        end

        // R7: pulse rate for word 0x1000
        load_word(32'h0000_1000);
        repeat (4) tick();
        pulses = 0;
        for (int i = 0; i < 256; i++) begin
            tick();
            pulses += int'(c16);
        end
        chk("R7", pulses, 32'd16);

        // R1: reset mid-run
        rst_n = 1'b0;
        tick();
        chk("R1", {31'b0, c16}, 32'd0);
        chk("R1", {16'b0, p16}, 32'd0);
        chk("R1", {19'b0, p13}, 32'd0);
        rst_n = 1'b1;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3 act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule